// File: doc/BRIEF.md
# Flag-Based Magnitude Comparator

This block compares two WIDTH-bit operands, `opa` and `opb`, with a single subtraction. It adds `opb` to the bitwise inverse of `opa` with a carry-in of one, which gives the difference `opb - opa`. From that one result it derives four condition flags: carry, zero, negative and overflow. The equal, unsigned and signed relations between the operands are then formed from those flags. A caller can use the same hardware for signed and for unsigned compares and pick the relation it needs.

Every relation output states how `opb` stands against `opa`. For example, `rel_ltu` means `opb < opa` when both are read as unsigned. The block also has a bitwise-equality path that works on its own, and two detectors on `opa` that report all-zeros and all-ones. The whole block is combinational. The adder is built either as an explicit bit-serial carry chain or as one behavioural add, and a parameter picks which.

Top module: `magcmp_flags`

## Requirements
- R1: `diff` equals (`opb` - `opa`) modulo 2^WIDTH for every operand pair.
- R2: `flag_c` is 1 exactly when `opb` >= `opa` as unsigned numbers, that is, when the subtraction needs no borrow.
- R3: `flag_z` is 1 exactly when every bit of `diff` is 0. `flag_n` equals bit WIDTH-1 of `diff`.
- R4: `flag_v` is 1 exactly when bit WIDTH-1 of `opa` and bit WIDTH-1 of `opb` differ and bit WIDTH-1 of `diff` differs from bit WIDTH-1 of `opb`.
- R5: `rel_eq` is the AND reduction of the bitwise XNOR of the operands, and `rel_ne` is its complement. `rel_eq` always agrees with `flag_z`.
- R6: Unsigned relations: `rel_ltu` = NOT C, `rel_geu` = C, `rel_leu` = (NOT C) OR Z, `rel_gtu` = C AND NOT Z. Each one matches the unsigned comparison of `opb` against `opa`.
- R7: Signed (two's complement) relations: `rel_lts` = N XOR V, `rel_ges` is its complement, `rel_les` = (N XOR V) OR Z, `rel_gts` is the complement of `rel_les`. Each one matches the signed comparison of `opb` against `opa`.
- R8: `opa_zero` is 1 exactly when all bits of `opa` are 0. `opa_ones` is 1 exactly when all bits of `opa` are 1.
- R9: Both adder variants (ADDER_STYLE 0 = carry chain, 1 = behavioural add) give identical outputs. WIDTH must be at least 2, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Subtrahend operand, also input to the zero/ones detectors |
| opb | input | WIDTH | Minuend operand |
| diff | output | WIDTH | opb - opa modulo 2^WIDTH |
| flag_c | output | 1 | Carry out of opb + ~opa + 1 |
| flag_z | output | 1 | Difference is zero |
| flag_n | output | 1 | Sign bit of the difference |
| flag_v | output | 1 | Signed overflow of the subtraction |
| rel_eq | output | 1 | opb equals opa |
| rel_ne | output | 1 | opb differs from opa |
| rel_ltu | output | 1 | opb < opa, unsigned |
| rel_geu | output | 1 | opb >= opa, unsigned |
| rel_leu | output | 1 | opb <= opa, unsigned |
| rel_gtu | output | 1 | opb > opa, unsigned |
| rel_lts | output | 1 | opb < opa, signed |
| rel_ges | output | 1 | opb >= opa, signed |
| rel_les | output | 1 | opb <= opa, signed |
| rel_gts | output | 1 | opb > opa, signed |
| opa_zero | output | 1 | opa is all zeros |
| opa_ones | output | 1 | opa is all ones |

## Verification
The bench builds two copies of the block. The first uses WIDTH=16 with the carry-chain adder. It receives every pairing of the corner values 0, 1, all-ones, the most negative value and the most positive value, followed by random pairs. The second uses WIDTH=4 with the behavioural adder. At that width all 256 operand pairs can be applied, so every overflow, borrow and sign combination is covered and the two adder variants are both exercised.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

   // Adder construction variants
   localparam int ADD_CHAIN = 0;
   localparam int ADD_BEHAV = 1;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } cond_flags_t;

   typedef struct packed {
      logic eq;
      logic ne;
      logic ltu;
      logic geu;
      logic leu;
      logic gtu;
      logic lts;
      logic ges;
      logic les;
      logic gts;
   } relations_t;

endpackage

// File: rtl/magcmp_sub.sv
module magcmp_sub #(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = magcmp_pkg::ADD_CHAIN
) (
   input  logic [WIDTH-1:0] minuend,
   input  logic [WIDTH-1:0] subtrahend,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   localparam int SUMW = WIDTH + 1;

   logic [WIDTH-1:0] inv_sub;
   assign inv_sub = ~subtrahend;

   generate
      if (ADDER_STYLE == magcmp_pkg::ADD_CHAIN) begin : g_chain
         always_comb begin
            logic cy;
            cy = 1'b1;
            result = '0;
            for (int i = 0; i < WIDTH; i++) begin
               result[i] = minuend[i] ^ inv_sub[i] ^ cy;
               cy = (minuend[i] & inv_sub[i]) | (cy & (minuend[i] ^ inv_sub[i]));
            end
            carry_out = cy;
         end
      end else begin : g_behav
         logic [SUMW-1:0] wide_sum;
         assign wide_sum  = {1'b0, minuend} + {1'b0, inv_sub} + SUMW'(1);
         assign result    = wide_sum[WIDTH-1:0];
         assign carry_out = wide_sum[SUMW-1];
      end
   endgenerate
endmodule

// File: rtl/magcmp_flaggen.sv
module magcmp_flaggen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]        minuend,
   input  logic [WIDTH-1:0]        subtrahend,
   input  logic [WIDTH-1:0]        result,
   input  logic                    carry_out,
   output magcmp_pkg::cond_flags_t flags
);
   localparam int MSB = WIDTH - 1;

   logic signs_differ;
   logic res_flipped;

   assign signs_differ = minuend[MSB] ^ subtrahend[MSB];
   assign res_flipped  = result[MSB] ^ minuend[MSB];

   assign flags.c = carry_out;
   assign flags.z = ~|result;
   assign flags.n = result[MSB];
   assign flags.v = signs_differ & res_flipped;
endmodule

// File: rtl/magcmp_detect.sv
module magcmp_detect #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic             same,
   output logic             a_zero,
   output logic             a_ones
);
   logic [WIDTH-1:0] bit_match;

   genvar g;
   generate
      for (g = 0; g < WIDTH; g++) begin : g_xnor
         assign bit_match[g] = ~(opa[g] ^ opb[g]);
      end
   endgenerate

   assign same   = &bit_match;
   assign a_ones = &opa;
   assign a_zero = ~|opa;
endmodule

// File: rtl/magcmp_relate.sv
module magcmp_relate (
   input  magcmp_pkg::cond_flags_t flags,
   input  logic                    same,
   output magcmp_pkg::relations_t  rel
);
   logic slt;
   assign slt = flags.n ^ flags.v;

   assign rel.eq  = same;
   assign rel.ne  = ~same;
   assign rel.ltu = ~flags.c;
   assign rel.geu = flags.c;
   assign rel.leu = ~flags.c | flags.z;
   assign rel.gtu = flags.c & ~flags.z;
   assign rel.lts = slt;
   assign rel.ges = ~slt;
   assign rel.les = slt | flags.z;
   assign rel.gts = ~(slt | flags.z);
endmodule

// File: rtl/magcmp_flags.sv
module magcmp_flags #(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = magcmp_pkg::ADD_CHAIN
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] diff,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_v,
   output logic             rel_eq,
   output logic             rel_ne,
   output logic             rel_ltu,
   output logic             rel_geu,
   output logic             rel_leu,
   output logic             rel_gtu,
   output logic             rel_lts,
   output logic             rel_ges,
   output logic             rel_les,
   output logic             rel_gts,
   output logic             opa_zero,
   output logic             opa_ones
);
   localparam int MSB = WIDTH - 1;

   // R9: elaboration-time parameter checks
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("magcmp_flags: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != magcmp_pkg::ADD_CHAIN && ADDER_STYLE != magcmp_pkg::ADD_BEHAV) begin : g_bad_style
         $error("magcmp_flags: unknown ADDER_STYLE");
      end
   endgenerate

   logic [WIDTH-1:0]        sub_res;
   logic                    sub_cy;
   magcmp_pkg::cond_flags_t cf;
   magcmp_pkg::relations_t  rl;
   logic                    same_w;

   magcmp_sub #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) sub_i (
      .minuend(opb), .subtrahend(opa), .result(sub_res), .carry_out(sub_cy));

   magcmp_flaggen #(.WIDTH(WIDTH)) flg_i (
      .minuend(opb), .subtrahend(opa), .result(sub_res), .carry_out(sub_cy), .flags(cf));

   magcmp_detect #(.WIDTH(WIDTH)) det_i (
      .opa(opa), .opb(opb), .same(same_w), .a_zero(opa_zero), .a_ones(opa_ones));

   magcmp_relate rel_i (.flags(cf), .same(same_w), .rel(rl));

   assign diff    = sub_res;
   assign flag_c  = cf.c;
   assign flag_z  = cf.z;
   assign flag_n  = cf.n;
   assign flag_v  = cf.v;
   assign rel_eq  = rl.eq;
   assign rel_ne  = rl.ne;
   assign rel_ltu = rl.ltu;
   assign rel_geu = rl.geu;
   assign rel_leu = rl.leu;
   assign rel_gtu = rl.gtu;
   assign rel_lts = rl.lts;
   assign rel_ges = rl.ges;
   assign rel_les = rl.les;
   assign rel_gts = rl.gts;

   // Cross-path consistency checks between the equality path and the subtractor
   always_comb begin
      assert_eq_tracks_zero_R5 : assert (rel_eq == flag_z)
         else $error("R5: equality path disagrees with zero flag");
      assert_equal_no_borrow_R2 : assert (!flag_z || flag_c)
         else $error("R2: zero difference produced a borrow");
      assert_no_overflow_R4 : assert ((opa[MSB] != opb[MSB]) || !flag_v)
         else $error("R4: overflow flagged for same-sign operands");
      assert_ult_excl_eq_R6 : assert (!(rel_ltu && rel_eq))
         else $error("R6: unsigned less-than while equal");
      assert_slt_excl_eq_R7 : assert (!(rel_lts && rel_eq))
         else $error("R7: signed less-than while equal");
      assert_detect_excl_R8 : assert (!(opa_zero && opa_ones))
         else $error("R8: operand both all-zeros and all-ones");
      assert_sign_is_msb_R3 : assert (flag_n == diff[MSB])
         else $error("R3: negative flag differs from difference msb");
   end
endmodule

// File: tb/magcmp_flags_tb.sv
module magcmp_flags_tb_top;
   localparam int WB = 16;
   localparam int WS = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [WB-1:0] a16 = '0, b16 = '0, d16;
   logic [WS-1:0] a4 = '0, b4 = '0, d4;
   logic [15:0]   o16, o4;   // {c,z,n,v,eq,ne,ltu,geu,leu,gtu,lts,ges,les,gts,az,ao}

   magcmp_flags #(.WIDTH(WB), .ADDER_STYLE(0)) dut_i (
      .opa(a16), .opb(b16), .diff(d16),
      .flag_c(o16[15]), .flag_z(o16[14]), .flag_n(o16[13]), .flag_v(o16[12]),
      .rel_eq(o16[11]), .rel_ne(o16[10]), .rel_ltu(o16[9]), .rel_geu(o16[8]),
      .rel_leu(o16[7]), .rel_gtu(o16[6]), .rel_lts(o16[5]), .rel_ges(o16[4]),
      .rel_les(o16[3]), .rel_gts(o16[2]), .opa_zero(o16[1]), .opa_ones(o16[0]));

   magcmp_flags #(.WIDTH(WS), .ADDER_STYLE(1)) dut_n4_i (
      .opa(a4), .opb(b4), .diff(d4),
      .flag_c(o4[15]), .flag_z(o4[14]), .flag_n(o4[13]), .flag_v(o4[12]),
      .rel_eq(o4[11]), .rel_ne(o4[10]), .rel_ltu(o4[9]), .rel_geu(o4[8]),
      .rel_leu(o4[7]), .rel_gtu(o4[6]), .rel_lts(o4[5]), .rel_ges(o4[4]),
      .rel_les(o4[3]), .rel_gts(o4[2]), .opa_zero(o4[1]), .opa_ones(o4[0]));

   string nm [16] = '{"R2 flag_c","R3 flag_z","R3 flag_n","R4 flag_v",
                      "R5 rel_eq","R5 rel_ne","R6 rel_ltu","R6 rel_geu",
                      "R6 rel_leu","R6 rel_gtu","R7 rel_lts","R7 rel_ges",
                      "R7 rel_les","R7 rel_gts","R8 opa_zero","R8 opa_ones"};

   // Behavioural reference: returns expected flag/relation vector and difference
   function automatic logic [15:0] model(input int w, input longint a, input longint b,
                                         output longint dexp);
      longint mask, ua, ub, sa, sb, sd, hi, lo;
      logic c, z, n, v, eq, ltu, lts;
      mask = (longint'(1) << w) - 1;
      ua = a & mask; ub = b & mask;
      sa = (ua >= (longint'(1) << (w-1))) ? ua - (longint'(1) << w) : ua;
      sb = (ub >= (longint'(1) << (w-1))) ? ub - (longint'(1) << w) : ub;
      dexp = (ub - ua) & mask;
      hi = (longint'(1) << (w-1)) - 1;
      lo = -(longint'(1) << (w-1));
      sd = sb - sa;
      c = (ub >= ua); z = (dexp == 0); n = ((dexp >> (w-1)) & 1) == 1;
      v = (sd > hi) || (sd < lo);
      eq = (ua == ub); ltu = (ub < ua); lts = (sb < sa);
      return {c, z, n, v, eq, !eq, ltu, !ltu, (ub <= ua), (ub > ua),
              lts, !lts, (sb <= sa), (sb > sa), (ua == 0), (ua == mask)};
   endfunction

   task automatic compare(input int w, input longint a, input longint b,
                          input logic [15:0] got, input longint dgot);
      logic [15:0] exp;
      longint dexp;
      exp = model(w, a, b, dexp);
      n_checks++;
      if (dgot != dexp) begin
         n_fail++;
         $display("FAIL R1 diff w=%0d a=%0h b=%0h actual=%0h expected=%0h", w, a, b, dgot, dexp);
      end
      for (int k = 0; k < 16; k++) begin
         n_checks++;
         if (got[15-k] !== exp[15-k]) begin
            n_fail++;
            $display("FAIL %s w=%0d a=%0h b=%0h actual=%0b expected=%0b",
                     nm[k], w, a, b, got[15-k], exp[15-k]);
         end
      end
   endtask

   task automatic apply16(input logic [WB-1:0] a, input logic [WB-1:0] b);
      @(negedge clk);
      a16 = a; b16 = b;
      @(posedge clk);
      #1 compare(WB, longint'(a), longint'(b), o16, longint'(d16));
   endtask

   initial begin
      logic [WB-1:0] corner [6];
      corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h8001};
      // Reset-equivalent state: both operands zero (R3, R5, R8)
      apply16('0, '0);
      // Corner pairings (R2, R4, R6, R7 overflow and borrow edges)
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            apply16(corner[i], corner[j]);
      // Random patterns (R1 through R8)
      for (int r = 0; r < 3000; r++)
         apply16(WB'($urandom), WB'($urandom));
      // Exhaustive narrow build with behavioural adder (R9)
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            a4 = WS'(i); b4 = WS'(j);
            @(posedge clk);
            #1 compare(WS, longint'(i), longint'(j), o4, longint'(d4));
         end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired before completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule